// File: doc/BRIEF.md
# Serial Slave Port to Byte FIFO Bridge

This block lets an external serial master move bytes into a transmit FIFO, take bytes out of a receive FIFO, and read or change a small status/control register. The serial clock, chip select and data-in lines are oversampled by a faster system clock through two-flop synchronizers. All protocol logic runs on the serial clock edges that the synchronized lines show. Chip select is active low. The slave samples data-in on rising serial clock edges and changes data-out on falling edges.

A frame holds twelve serial clock periods. It starts with a start bit of 1, then a direction bit (1 read, 0 write), then an address bit (0 data FIFO, 1 status/control register). Eight data bits follow, most significant first. The last period is a handshake bit that the slave drives: 0 means the byte was accepted or is valid, 1 means busy (transmit FIFO full on a write, receive FIFO empty on a read). On a busy answer the master repeats the frame. A FIFO push, FIFO pop or register update happens only on the rising edge of the handshake bit. A frame cut short by releasing chip select therefore leaves every piece of state as it was.

The status byte has the receive-empty flag in bit 0, the transmit-full flag in bit 1, the receive interrupt enable in bit 4 and the transmit interrupt enable in bit 5. Every other bit reads 0. An interrupt output combines the enables with the FIFO flags.

Top module: `spi_fifo_bridge`

## Requirements
- R1: After reset, spi_miso and irq are 0, tx_push and rx_pop are idle, and both interrupt enables read back as 0.
- R2: A write frame to address 0 with tx_full low produces exactly one tx_push pulse. tx_data equals the shifted byte, taken MSB first. The handshake bit is 0.
- R3: A write frame to address 0 with tx_full high produces no tx_push, and the handshake bit is 1.
- R4: A read frame to address 0 with rx_empty low shifts rx_data out MSB first. Each bit changes on a falling serial clock edge. The handshake bit is 0, and exactly one rx_pop pulse follows.
- R5: A read frame to address 0 with rx_empty high gives handshake bit 1 and no rx_pop.
- R6: A read frame to address 1 returns a status byte: bit 0 = rx_empty, bit 1 = tx_full, bit 4 = receive enable, bit 5 = transmit enable, all other bits 0. The handshake bit is 0, and no FIFO pulse occurs.
- R7: A write frame to address 1 loads only bits 4 and 5 of the byte into the two enables. The handshake bit is 0, and no FIFO pulse occurs.
- R8: irq is 1 exactly when (receive enable and rx_empty low) or (transmit enable and tx_full low).
- R9: Releasing chip select before the handshake rising edge aborts the frame, with no push, no pop and no enable change. The next full frame works normally.
- R10: spi_miso is 0 while chip select is released, and tx_push and rx_pop are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data and handshake bit to the master |
| rx_data | input | DATA_W | Head byte of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_pop | output | 1 | One-cycle pop strobe to the receive FIFO |
| tx_data | output | DATA_W | Byte to push into the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO is full |
| tx_push | output | 1 | One-cycle push strobe to the transmit FIFO |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit data and two synchronizer stages. Its serial clock half period is six system clocks. With these values the three-cycle path from a synchronized falling edge to a new data-out bit finishes well before the master samples. Every frame shape can then be walked bit by bit, including frames cut off after the last data bit, one edge before the commit point. Holding the FIFO flags fixed across a frame lets the bench force the full and empty answers and every interrupt term on demand.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_ADDR,
        ST_DATA,
        ST_HS,
        ST_DONE
    } sfb_state_e;

    localparam int STAT_RXE_BIT  = 0;
    localparam int STAT_TXF_BIT  = 1;
    localparam int STAT_RXIE_BIT = 4;
    localparam int STAT_TXIE_BIT = 5;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic mosi;
    } sfb_pins_t;

    localparam sfb_pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, mosi: 1'b0};

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
    } sfb_ctrl_t;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic to_status;
        logic busy;
    } sfb_commit_t;

    function automatic logic [7:0] sfb_status(input logic rx_empty,
                                              input logic tx_full,
                                              input sfb_ctrl_t ctrl);
        logic [7:0] s;
        s = 8'h00;
        s[STAT_RXE_BIT]  = rx_empty;
        s[STAT_TXF_BIT]  = tx_full;
        s[STAT_RXIE_BIT] = ctrl.rx_ie;
        s[STAT_TXIE_BIT] = ctrl.tx_ie;
        return s;
    endfunction

endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfb_front.sv
module sfb_front
    import sfb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    sfb_pins_t pins_raw, pins_s;
    logic      sclk_prev;

    assign pins_raw = '{sclk: spi_sclk, cs_n: spi_cs_n, mosi: spi_mosi};

    sfb_sync #(
        .W       ($bits(sfb_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= pins_s.sclk;
    end

    assign sclk_rise = pins_s.sclk & ~sclk_prev;
    assign sclk_fall = ~pins_s.sclk & sclk_prev;
    assign cs_act    = ~pins_s.cs_n;
    assign mosi_s    = pins_s.mosi;
endmodule

// File: rtl/sfb_engine.sv
module sfb_engine
    import sfb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    input  logic              tx_full,
    input  logic [7:0]        status,
    output logic [DATA_W-1:0] shreg,
    output logic              miso,
    output sfb_commit_t       commit
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    sfb_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             dir_rd;
    logic             adr_st;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            miso   <= 1'b0;
            commit <= '0;
            if (rst) begin
                dir_rd <= 1'b0;
                adr_st <= 1'b0;
                busy   <= 1'b0;
                shreg  <= '0;
            end
        end else begin
            commit.valid <= 1'b0;
            if (sclk_rise) begin
                unique case (state)
                    ST_IDLE: if (mosi_s) state <= ST_DIR;
                    ST_DIR: begin
                        dir_rd <= mosi_s;
                        state  <= ST_ADDR;
                    end
                    ST_ADDR: begin
                        adr_st <= mosi_s;
                        cnt    <= '0;
                        state  <= ST_DATA;
                        if (dir_rd) begin
                            shreg <= mosi_s ? DATA_W'(status) : rx_data;
                            busy  <= ~mosi_s & rx_empty;
                        end else begin
                            busy  <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        if (!dir_rd) shreg <= {shreg[DATA_W-2:0], mosi_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_LAST) begin
                            state <= ST_HS;
                            if (!dir_rd && !adr_st) busy <= tx_full;
                        end
                    end
                    ST_HS: begin
                        commit <= '{valid: 1'b1, is_read: dir_rd,
                                    to_status: adr_st, busy: busy};
                        state  <= ST_DONE;
                    end
                    default: ;
                endcase
            end else if (sclk_fall) begin
                unique case (state)
                    ST_DATA: begin
                        if (dir_rd) begin
                            miso  <= shreg[DATA_W-1];
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                    ST_HS:   miso <= busy;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
    import sfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  sfb_ctrl_t  wr_val,
    input  logic       rx_empty,
    input  logic       tx_full,
    output logic [7:0] status,
    output logic       irq
);
    sfb_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (wr) ctrl_q <= wr_val;
    end

    assign status = sfb_status(rx_empty, tx_full, ctrl_q);
    assign irq    = (ctrl_q.rx_ie & ~rx_empty) | (ctrl_q.tx_ie & ~tx_full);
endmodule

// File: rtl/spi_fifo_bridge.sv
module spi_fifo_bridge
    import sfb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    output logic              rx_pop,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_full,
    output logic              tx_push,
    output logic              irq
);
    logic        sclk_rise, sclk_fall, cs_act, mosi_s;
    logic [7:0]  status;
    sfb_commit_t commit;
    sfb_ctrl_t   wr_val;
    logic        ctrl_wr;

    sfb_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    sfb_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s),
        .rx_data   (rx_data),
        .rx_empty  (rx_empty),
        .tx_full   (tx_full),
        .status    (status),
        .shreg     (tx_data),
        .miso      (spi_miso),
        .commit    (commit)
    );

    assign wr_val  = '{rx_ie: tx_data[STAT_RXIE_BIT], tx_ie: tx_data[STAT_TXIE_BIT]};
    assign ctrl_wr = commit.valid & ~commit.is_read & commit.to_status;
    assign tx_push = commit.valid & ~commit.is_read & ~commit.to_status & ~commit.busy;
    assign rx_pop  = commit.valid &  commit.is_read & ~commit.to_status & ~commit.busy;

    sfb_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctrl_wr),
        .wr_val   (wr_val),
        .rx_empty (rx_empty),
        .tx_full  (tx_full),
        .status   (status),
        .irq      (irq)
    );
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic rx_empty,
    input logic rx_pop,
    input logic tx_full,
    input logic tx_push,
    input logic irq
);
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_push |=> !tx_push); // R2
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> !tx_full); // R3
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_pop |=> !rx_pop); // R4
    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !rx_empty); // R5
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && tx_full) |-> !irq); // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(tx_push && rx_pop)); // R10
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso); // R10
endmodule

bind spi_fifo_bridge sfb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .rx_empty (rx_empty),
    .rx_pop   (rx_pop),
    .tx_full  (tx_full),
    .tx_push  (tx_push),
    .irq      (irq)
);

// File: tb/spi_fifo_bridge_bench.sv
module spi_fifo_bridge_bench;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] rx_data = 8'h00;
    logic       rx_empty = 1'b0, tx_full = 1'b0;
    logic       rx_pop, tx_push, irq;
    logic [7:0] tx_data;

    int errors = 0, checks = 0;
    int push_cnt = 0, pop_cnt = 0;
    logic [7:0] push_byte = 8'h00;
    bit done = 0;

    always #10 clk = ~clk;

    spi_fifo_bridge u_spi_fifo_bridge (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_pop(rx_pop), .tx_data(tx_data),
        .tx_full(tx_full), .tx_push(tx_push), .irq(irq)
    );

    always @(posedge clk) begin
        if (tx_push) begin push_cnt <= push_cnt + 1; push_byte <= tx_data; end
        if (rx_pop)  pop_cnt <= pop_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    // Full frame has 12 bits; nbits < 12 releases chip select early.
    task automatic xfer(input logic rd, input logic adr, input logic [7:0] wb,
                        input int nbits, output logic [7:0] rb, output logic hs);
        rb = 8'h00; hs = 1'b0;
        push_cnt = 0; pop_cnt = 0;
        spi_cs_n = 1'b0;
        half();
        for (int i = 0; i < nbits; i++) begin
            if (i == 0)      spi_mosi = 1'b1;
            else if (i == 1) spi_mosi = rd;
            else if (i == 2) spi_mosi = adr;
            else if (i <= 10) spi_mosi = wb[10-i];
            else             spi_mosi = 1'b0;
            half();
            if (i >= 3 && i <= 10) rb[10-i] = spi_miso;
            if (i == 11) hs = spi_miso;
            spi_sclk = 1'b1;
            half();
            spi_sclk = 1'b0;
        end
        half(); half();
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (4) half();
    endtask

    // {rd, adr, wb[8], rxe, rxd[8], txf, exp_b[8], exp_hs, exp_pop, exp_push, chk_b, req[4]}
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0,1'b0,8'hA5, 1'b1,8'h00, 1'b0, 8'h00, 1'b0,1'b0,1'b1,1'b0, 4'd2}, // R2 write accepted
        {1'b0,1'b0,8'h3C, 1'b1,8'h00, 1'b1, 8'h00, 1'b1,1'b0,1'b0,1'b0, 4'd3}, // R3 write busy
        {1'b1,1'b0,8'h00, 1'b0,8'h5A, 1'b0, 8'h5A, 1'b0,1'b1,1'b0,1'b1, 4'd4}, // R4 read data
        {1'b1,1'b0,8'h00, 1'b1,8'hC3, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 read empty
        {1'b1,1'b1,8'h00, 1'b1,8'h00, 1'b1, 8'h03, 1'b0,1'b0,1'b0,1'b1, 4'd1}, // R1 enables clear
        {1'b0,1'b1,8'hFF, 1'b1,8'h00, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0, 4'd7}, // R7 set both
        {1'b1,1'b1,8'h00, 1'b0,8'h00, 1'b0, 8'h30, 1'b0,1'b0,1'b0,1'b1, 4'd6}, // R6 status
        {1'b0,1'b1,8'h10, 1'b1,8'h00, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0, 4'd7}, // R7 rx only
        {1'b1,1'b1,8'h00, 1'b1,8'h00, 1'b0, 8'h11, 1'b0,1'b0,1'b0,1'b1, 4'd7}, // R7 readback
        {1'b1,1'b1,8'h00, 1'b0,8'h00, 1'b1, 8'h12, 1'b0,1'b0,1'b0,1'b1, 4'd6}  // R6 tx flag
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rb;
        logic hs;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(spi_miso == 1'b0, "R1 miso", int'(spi_miso), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(tx_push == 1'b0 && rx_pop == 1'b0, "R1 strobes", int'({tx_push, rx_pop}), 0);

        for (int v = 0; v < NV; v++) begin
            logic [35:0] e;
            string tag;
            e = VEC[v];
            tag = $sformatf("R%0d row%0d", e[3:0], v);
            rx_empty = e[25];
            rx_data  = e[24:17];
            tx_full  = e[16];
            xfer(e[35], e[34], e[33:26], 12, rb, hs);
            chk(hs == e[7], {tag, " handshake"}, int'(hs), int'(e[7]));
            chk(pop_cnt == int'(e[6]), {tag, " pops"}, pop_cnt, int'(e[6]));
            chk(push_cnt == int'(e[5]), {tag, " pushes"}, push_cnt, int'(e[5]));
            if (e[5]) chk(push_byte == e[33:26], {tag, " pushed byte"}, int'(push_byte), int'(e[33:26]));
            if (e[4]) chk(rb == e[15:8], {tag, " read byte"}, int'(rb), int'(e[15:8]));
            chk(spi_miso == 1'b0, "R10 miso idle", int'(spi_miso), 0);
        end

        // R8: receive enable only is set now
        rx_empty = 1'b0; tx_full = 1'b0; repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R8 rx term", int'(irq), 1);
        rx_empty = 1'b1; repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R8 tx disabled", int'(irq), 0);
        xfer(1'b0, 1'b1, 8'h20, 12, rb, hs);
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R8 tx term", int'(irq), 1);
        tx_full = 1'b1; repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R8 none", int'(irq), 0);

        // R9: aborts one edge before commit
        tx_full = 1'b0; rx_empty = 1'b0; rx_data = 8'h77;
        xfer(1'b0, 1'b0, 8'h99, 11, rb, hs);
        chk(push_cnt == 0, "R9 abort write", push_cnt, 0);
        xfer(1'b1, 1'b0, 8'h00, 11, rb, hs);
        chk(pop_cnt == 0, "R9 abort read", pop_cnt, 0);
        xfer(1'b0, 1'b1, 8'h10, 11, rb, hs);
        xfer(1'b0, 1'b0, 8'h66, 5, rb, hs);
        chk(push_cnt == 0, "R9 abort short", push_cnt, 0);
        xfer(1'b1, 1'b1, 8'h00, 12, rb, hs);
        chk(rb == 8'h20, "R9 enables kept", int'(rb), 32'h20);
        xfer(1'b0, 1'b0, 8'hC5, 12, rb, hs);
        chk(push_cnt == 1 && push_byte == 8'hC5, "R9 recovery", int'(push_byte), 32'hC5);
        chk(hs == 1'b0, "R9 recovery handshake", int'(hs), 0);

        finish_run();
    end
endmodule